// File: doc/BRIEF.md
# Outbound Address Translation Window

This block rewrites the address of an outgoing request from the local address space into a bus-side address. A small number of programmable regions each hold a 64-bit base, a 32-bit limit word, a 64-bit target, a transaction type and an enable bit. Software does not address the regions directly. It first writes a selector word that names a direction and a region index. Every later access to the region-field offsets then reads or writes the region that the selector names.

On the request side, a valid address is compared against all enabled regions in parallel. The lowest-indexed region that matches supplies the translated address, computed as target plus the offset of the address from the base, together with its transaction type. If no region matches, the address is returned unchanged and a miss flag is raised. The result appears one clock after the request. The register port is a single-cycle write port with a combinational read of the offset on `cfgAddr`.

Top module: `outb_xlat_window`

## Requirements
- R1: After synchronous reset, `rspValid` is 0, the selector word reads 0 (outbound, index 0), and every region field reads 0 with the region disabled.
- R2: Offset 0x900 holds the selector. Bit 31 is direction (1 = inbound, 0 = outbound) and bits 3:0 are the region index. It reads back as written in those bits and reads 0 in all other bits.
- R3: Region fields are at offsets 0x904 (type, bits 4:0), 0x908 (bit 31 enable, bit 30 BAR-mode flag, other bits 0), 0x90C (base low), 0x910 (base high), 0x914 (limit) and 0x918/0x91C (target low/high). Writes and reads act on the region named by the selector.
- R4: While the selector names an inbound region or an index of NREG or above, writes to region offsets are ignored, reads of them return 0, and translation is unaffected.
- R5: A region hits when it is enabled, request bits 63:32 equal its base high, and base low <= request bits 31:0 <= limit, with both ends inclusive. On a hit, the next cycle gives `rspAddr` = target + (request - base), `rspType` = the region type, `rspMiss` = 0 and `rspRegion` = the region index.
- R6: A disabled region never hits, whatever its other fields hold.
- R7: When several regions hit, the lowest index wins.
- R8: When no region hits, the next cycle gives `rspAddr` equal to the request address, `rspMiss` = 1, `rspType` = 0 and `rspRegion` = 0.
- R9: The type field is carried to `rspType` verbatim: memory 0, I/O 2, configuration type 0 = 4, configuration type 1 = 5. In a configuration region, the bus (31:24), device (23:19) and function (18:16) bits of the target low word reach the output unchanged while the offset into the region stays below 0x10000.
- R10: A request in the same cycle as a region-field write is translated with the values from before the write.
- R11: `rspValid` is 1 exactly one cycle after a cycle with `reqValid` = 1, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 12 | Register offset for read and write |
| cfgWdata | input | 32 | Register write data |
| cfgRdata | output | 32 | Combinational read data for `cfgAddr` |
| reqValid | input | 1 | Request address is valid |
| reqAddr | input | 64 | Local request address |
| rspValid | output | 1 | Translation result valid |
| rspAddr | output | 64 | Translated or passed-through address |
| rspType | output | 5 | Transaction type of the winning region |
| rspMiss | output | 1 | No enabled region matched |
| rspRegion | output | 1 | Index of the winning region |

## Verification
The two functions that can fall in the same cycle are a region-field write and a translation of a request that the write would change. The bench provokes this by driving, on one edge, a write that shrinks a region's limit together with a request just above the new limit. It then expects a hit computed from the old limit, and expects a miss for the identical request on the following cycle. Every cycle, a behavioural reference model applies pending writes only after it has computed the expected result. Any design that lets a write bypass into the comparator therefore shows up as a mismatch on `rspAddr` or `rspMiss`.

// File: rtl/outb_xlat_pkg.sv
package outb_xlat_pkg;

  localparam int DATA_W = 32;
  localparam int TYPE_W = 5;

  localparam logic [11:0] OFS_SEL   = 12'h900;
  localparam logic [11:0] OFS_TYPE  = 12'h904;
  localparam logic [11:0] OFS_CTL   = 12'h908;
  localparam logic [11:0] OFS_BLO   = 12'h90C;
  localparam logic [11:0] OFS_BHI   = 12'h910;
  localparam logic [11:0] OFS_LIM   = 12'h914;
  localparam logic [11:0] OFS_TLO   = 12'h918;
  localparam logic [11:0] OFS_THI   = 12'h91C;

  typedef enum logic [3:0] {
    FLD_NONE, FLD_SEL, FLD_TYPE, FLD_CTL, FLD_BLO,
    FLD_BHI, FLD_LIM, FLD_TLO, FLD_THI
  } fieldSel_e;

  // write strobes from the control half to the region storage
  typedef struct packed {
    logic wrType;
    logic wrCtl;
    logic wrBaseLo;
    logic wrBaseHi;
    logic wrLimit;
    logic wrTgtLo;
    logic wrTgtHi;
  } winStrobe_t;

endpackage

// File: rtl/outb_xlat_ctrl.sv
module outb_xlat_ctrl
  import outb_xlat_pkg::*;
#(
  parameter int NREG     = 2,
  parameter int SEL_IDXW = 4,
  parameter int IDX_W    = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfgWe,
  input  logic [11:0]       cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [DATA_W-1:0] regionWord,
  output logic [DATA_W-1:0] cfgRdata,
  output winStrobe_t        wrStb,
  output fieldSel_e         rdField,
  output logic [IDX_W-1:0]  regionIdx,
  output logic [DATA_W-1:0] selWord
);

  logic                selInbound;
  logic [SEL_IDXW-1:0] selIdx;
  logic                regionOk;
  fieldSel_e           field;

  always_comb begin
    unique case (cfgAddr)
      OFS_SEL:  field = FLD_SEL;
      OFS_TYPE: field = FLD_TYPE;
      OFS_CTL:  field = FLD_CTL;
      OFS_BLO:  field = FLD_BLO;
      OFS_BHI:  field = FLD_BHI;
      OFS_LIM:  field = FLD_LIM;
      OFS_TLO:  field = FLD_TLO;
      OFS_THI:  field = FLD_THI;
      default:  field = FLD_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      selInbound <= 1'b0;
      selIdx     <= '0;
    end else if (cfgWe && field == FLD_SEL) begin
      selInbound <= cfgWdata[DATA_W-1];
      selIdx     <= cfgWdata[SEL_IDXW-1:0];
    end
  end

  assign regionOk  = !selInbound && (int'(selIdx) < NREG);
  assign regionIdx = selIdx[IDX_W-1:0];
  assign selWord   = {selInbound, {(DATA_W-1-SEL_IDXW){1'b0}}, selIdx};
  assign rdField   = field;

  always_comb begin
    wrStb          = '0;
    wrStb.wrType   = cfgWe && regionOk && field == FLD_TYPE;
    wrStb.wrCtl    = cfgWe && regionOk && field == FLD_CTL;
    wrStb.wrBaseLo = cfgWe && regionOk && field == FLD_BLO;
    wrStb.wrBaseHi = cfgWe && regionOk && field == FLD_BHI;
    wrStb.wrLimit  = cfgWe && regionOk && field == FLD_LIM;
    wrStb.wrTgtLo  = cfgWe && regionOk && field == FLD_TLO;
    wrStb.wrTgtHi  = cfgWe && regionOk && field == FLD_THI;
  end

  always_comb begin
    if (field == FLD_SEL)                     cfgRdata = selWord;
    else if (field != FLD_NONE && regionOk)   cfgRdata = regionWord;
    else                                      cfgRdata = '0;
  end

endmodule

// File: rtl/outb_xlat_dpath.sv
module outb_xlat_dpath
  import outb_xlat_pkg::*;
#(
  parameter int NREG  = 2,
  parameter int IDX_W = 1
) (
  input  logic                clk,
  input  logic                rst,
  input  winStrobe_t          wrStb,
  input  logic [IDX_W-1:0]    regionIdx,
  input  logic [DATA_W-1:0]   cfgWdata,
  input  fieldSel_e           rdField,
  output logic [DATA_W-1:0]   regionWord,
  input  logic                reqValid,
  input  logic [2*DATA_W-1:0] reqAddr,
  output logic                rspValid,
  output logic [2*DATA_W-1:0] rspAddr,
  output logic [TYPE_W-1:0]   rspType,
  output logic                rspMiss,
  output logic [IDX_W-1:0]    rspRegion
);

  localparam int ADDR_W = 2 * DATA_W;

  logic [TYPE_W-1:0] rType [NREG];
  logic              rEn   [NREG];
  logic              rBar  [NREG];
  logic [DATA_W-1:0] rBlo  [NREG];
  logic [DATA_W-1:0] rBhi  [NREG];
  logic [DATA_W-1:0] rLim  [NREG];
  logic [DATA_W-1:0] rTlo  [NREG];
  logic [DATA_W-1:0] rThi  [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst) begin
        rType[i] <= '0; rEn[i] <= 1'b0; rBar[i] <= 1'b0;
        rBlo[i]  <= '0; rBhi[i] <= '0;  rLim[i] <= '0;
        rTlo[i]  <= '0; rThi[i] <= '0;
      end else if (int'(regionIdx) == i) begin
        if (wrStb.wrType)   rType[i] <= cfgWdata[TYPE_W-1:0];
        if (wrStb.wrCtl) begin
          rEn[i]  <= cfgWdata[DATA_W-1];
          rBar[i] <= cfgWdata[DATA_W-2];
        end
        if (wrStb.wrBaseLo) rBlo[i] <= cfgWdata;
        if (wrStb.wrBaseHi) rBhi[i] <= cfgWdata;
        if (wrStb.wrLimit)  rLim[i] <= cfgWdata;
        if (wrStb.wrTgtLo)  rTlo[i] <= cfgWdata;
        if (wrStb.wrTgtHi)  rThi[i] <= cfgWdata;
      end
    end
  end

  // per-region window match, evaluated in parallel
  logic [NREG-1:0] hitVec;
  for (genvar g = 0; g < NREG; g++) begin : g_match
    assign hitVec[g] = rEn[g]
                    && reqAddr[ADDR_W-1:DATA_W] == rBhi[g]
                    && reqAddr[DATA_W-1:0] >= rBlo[g]
                    && reqAddr[DATA_W-1:0] <= rLim[g];
  end

  logic [IDX_W-1:0]  winIdx;
  logic              anyHit;
  logic [ADDR_W-1:0] xlatAddr;

  always_comb begin
    winIdx = '0;
    anyHit = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        winIdx = IDX_W'(i);
        anyHit = 1'b1;
      end
    end
  end

  // one shared offset adder behind the winner mux
  assign xlatAddr = {rThi[winIdx], rTlo[winIdx]}
                  + (reqAddr - {rBhi[winIdx], rBlo[winIdx]});

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      rspAddr   <= '0;
      rspType   <= '0;
      rspMiss   <= 1'b0;
      rspRegion <= '0;
    end else begin
      rspValid  <= reqValid;
      rspAddr   <= anyHit ? xlatAddr : reqAddr;
      rspType   <= anyHit ? rType[winIdx] : '0;
      rspMiss   <= !anyHit;
      rspRegion <= anyHit ? winIdx : '0;
    end
  end

  always_comb begin
    unique case (rdField)
      FLD_TYPE: regionWord = {{(DATA_W-TYPE_W){1'b0}}, rType[regionIdx]};
      FLD_CTL:  regionWord = {rEn[regionIdx], rBar[regionIdx], {(DATA_W-2){1'b0}}};
      FLD_BLO:  regionWord = rBlo[regionIdx];
      FLD_BHI:  regionWord = rBhi[regionIdx];
      FLD_LIM:  regionWord = rLim[regionIdx];
      FLD_TLO:  regionWord = rTlo[regionIdx];
      FLD_THI:  regionWord = rThi[regionIdx];
      default:  regionWord = '0;
    endcase
  end

endmodule

// File: rtl/outb_xlat_window.sv
module outb_xlat_window
  import outb_xlat_pkg::*;
#(
  parameter int NREG     = 2,
  parameter int SEL_IDXW = 4,
  localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfgWe,
  input  logic [11:0]         cfgAddr,
  input  logic [DATA_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]   cfgRdata,
  input  logic                reqValid,
  input  logic [2*DATA_W-1:0] reqAddr,
  output logic                rspValid,
  output logic [2*DATA_W-1:0] rspAddr,
  output logic [TYPE_W-1:0]   rspType,
  output logic                rspMiss,
  output logic [IDX_W-1:0]    rspRegion
);

  winStrobe_t        wrStb;
  fieldSel_e         rdField;
  logic [IDX_W-1:0]  regionIdx;
  logic [DATA_W-1:0] regionWord;
  logic [DATA_W-1:0] selWord;

  outb_xlat_ctrl #(.NREG(NREG), .SEL_IDXW(SEL_IDXW), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .regionWord(regionWord), .cfgRdata(cfgRdata), .wrStb(wrStb),
    .rdField(rdField), .regionIdx(regionIdx), .selWord(selWord)
  );

  outb_xlat_dpath #(.NREG(NREG), .IDX_W(IDX_W)) dpath_i (
    .clk(clk), .rst(rst), .wrStb(wrStb), .regionIdx(regionIdx),
    .cfgWdata(cfgWdata), .rdField(rdField), .regionWord(regionWord),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspAddr(rspAddr), .rspType(rspType), .rspMiss(rspMiss),
    .rspRegion(rspRegion)
  );

endmodule

// File: rtl/outb_xlat_window_chk.sv
module outb_xlat_window_chk
  import outb_xlat_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                cfgWe,
  input logic [11:0]         cfgAddr,
  input logic                reqValid,
  input logic [2*DATA_W-1:0] reqAddr,
  input logic                rspValid,
  input logic [2*DATA_W-1:0] rspAddr,
  input logic                rspMiss,
  input logic [DATA_W-1:0]   selWord
);

  logic pastRst;
  always_ff @(posedge clk) pastRst <= rst;

  // R1: the cycle after a reset edge shows no result and a cleared selector
  always @(posedge clk) begin
    if (pastRst === 1'b1)
      a_r1_idle_after_reset: assert (!rspValid && selWord == '0);
  end

  // R2: the selector only moves on a write to its own offset
  a_r2_sel_holds: assert property (@(posedge clk) disable iff (rst)
    !(cfgWe && cfgAddr == OFS_SEL) |=> $stable(selWord));

  // R8: a miss returns the request address untouched
  a_r8_miss_passthru: assert property (@(posedge clk) disable iff (rst)
    (rspValid && rspMiss) |-> rspAddr == $past(reqAddr));

  // R11: result strobe follows the request strobe by one cycle
  a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);
  a_r11_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !rspValid);

endmodule

bind outb_xlat_window outb_xlat_window_chk chk_i (
  .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
  .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
  .rspAddr(rspAddr), .rspMiss(rspMiss), .selWord(selWord)
);

// File: tb/outb_xlat_window_tb_top.sv
`timescale 1ns/1ps
module outb_xlat_window_tb_top;

  localparam int NREG = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfgWe;
  logic [11:0] cfgAddr;
  logic [31:0] cfgWdata;
  logic [31:0] cfgRdata;
  logic        reqValid;
  logic [63:0] reqAddr;
  logic        rspValid;
  logic [63:0] rspAddr;
  logic [4:0]  rspType;
  logic        rspMiss;
  logic [0:0]  rspRegion;

  always #2 clk = ~clk;

  outb_xlat_window #(.NREG(NREG)) dut_i (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspType(rspType), .rspMiss(rspMiss), .rspRegion(rspRegion)
  );

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  // ---------------- behavioural reference model ----------------
  logic        mInb;
  logic [3:0]  mIdx;
  logic [4:0]  mType [NREG];
  logic        mEn   [NREG];
  logic [31:0] mBlo  [NREG];
  logic [31:0] mBhi  [NREG];
  logic [31:0] mLim  [NREG];
  logic [31:0] mTlo  [NREG];
  logic [31:0] mThi  [NREG];
  logic        eValid;
  logic [63:0] eAddr;
  logic [4:0]  eType;
  logic        eMiss;
  logic        eReg;

  always @(posedge clk) begin
    if (rst) begin
      mInb = 1'b0; mIdx = '0; eValid = 1'b0;
      for (int i = 0; i < NREG; i++) begin
        mType[i] = '0; mEn[i] = 1'b0; mBlo[i] = '0; mBhi[i] = '0;
        mLim[i] = '0; mTlo[i] = '0; mThi[i] = '0;
      end
    end else begin
      bit found;
      found  = 1'b0;
      eValid = reqValid; eAddr = reqAddr; eType = '0; eMiss = 1'b1; eReg = 1'b0;
      for (int i = 0; i < NREG; i++) begin
        if (!found && mEn[i] && reqAddr[63:32] == mBhi[i] &&
            reqAddr[31:0] >= mBlo[i] && reqAddr[31:0] <= mLim[i]) begin
          found = 1'b1;
          eAddr = {mThi[i], mTlo[i]} + (reqAddr - {mBhi[i], mBlo[i]});
          eType = mType[i]; eMiss = 1'b0; eReg = i[0];
        end
      end
      if (cfgWe) begin
        if (cfgAddr == 12'h900) begin
          mInb = cfgWdata[31]; mIdx = cfgWdata[3:0];
        end else if (!mInb && int'(mIdx) < NREG) begin
          case (cfgAddr)
            12'h904: mType[mIdx] = cfgWdata[4:0];
            12'h908: mEn[mIdx]   = cfgWdata[31];
            12'h90C: mBlo[mIdx]  = cfgWdata;
            12'h910: mBhi[mIdx]  = cfgWdata;
            12'h914: mLim[mIdx]  = cfgWdata;
            12'h918: mTlo[mIdx]  = cfgWdata;
            12'h91C: mThi[mIdx]  = cfgWdata;
            default: ;
          endcase
        end
      end
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst === 1'b0 && !done) begin
      nTests++;
      if (rspValid !== eValid ||
          (eValid && (rspAddr !== eAddr || rspType !== eType ||
                      rspMiss !== eMiss || rspRegion !== eReg))) begin
        nFail++;
        $display("FAIL %s model compare: actual v=%0b a=%h t=%0d m=%0b r=%0d expected v=%0b a=%h t=%0d m=%0b r=%0d",
                 !eValid ? "R11" : (eMiss ? "R8" : "R5"),
                 rspValid, rspAddr, rspType, rspMiss, rspRegion,
                 eValid, eAddr, eType, eMiss, eReg);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input bit rv, input logic [63:0] ra);
    cfgWe = we; cfgAddr = a; cfgWdata = d; reqValid = rv; reqAddr = ra;
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step(1'b1, a, d, 1'b0, '0);
  endtask

  task automatic req(input logic [63:0] ra);
    step(1'b0, 12'h000, '0, 1'b1, ra);
  endtask

  task automatic rdExp(input logic [11:0] a, input logic [31:0] exp, input string tag);
    cfgWe = 1'b0; reqValid = 1'b0; cfgAddr = a;
    #1;
    nTests++;
    if (cfgRdata !== exp) begin
      nFail++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, cfgRdata, exp);
    end
    @(negedge clk);
  endtask

  task automatic chkRsp(input logic [63:0] ea, input logic [4:0] et,
                        input bit em, input bit er, input string tag);
    nTests++;
    if (rspValid !== 1'b1 || rspAddr !== ea || rspType !== et ||
        rspMiss !== em || rspRegion !== er) begin
      nFail++;
      $display("FAIL %s response: actual v=%0b a=%h t=%0d m=%0b r=%0d expected v=1 a=%h t=%0d m=%0b r=%0d",
               tag, rspValid, rspAddr, rspType, rspMiss, rspRegion, ea, et, em, er);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL R11 watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // ---------------- directed and random sequence ----------------
  initial begin
    rst = 1'b1; cfgWe = 1'b0; cfgAddr = '0; cfgWdata = '0;
    reqValid = 1'b0; reqAddr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    nTests++;
    if (rspValid !== 1'b0) begin
      nFail++; $display("FAIL R1 rspValid after reset: actual %0b expected 0", rspValid);
    end
    rdExp(12'h900, 32'h0, "R1");
    rdExp(12'h908, 32'h0, "R1");
    rdExp(12'h90C, 32'h0, "R1");
    rdExp(12'h91C, 32'h0, "R1");

    // R2: selector keeps only direction and index bits
    wr(12'h900, 32'h7FFF_FFF1);
    rdExp(12'h900, 32'h0000_0001, "R2");

    // program region 0: memory window
    wr(12'h900, 32'h0);
    wr(12'h904, 32'hFFFF_FFE0);
    wr(12'h90C, 32'h1000_0000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h1000_FFFF);
    wr(12'h918, 32'h0);
    wr(12'h91C, 32'h0000_0080);
    wr(12'h908, 32'h8000_0000);
    // program region 1: configuration type 0, bus 3 dev 5 func 2
    wr(12'h900, 32'h1);
    wr(12'h904, 32'h4);
    wr(12'h90C, 32'h1000_8000);
    wr(12'h910, 32'h0000_0001);
    wr(12'h914, 32'h1001_0FFF);
    wr(12'h918, 32'h032A_0000);
    wr(12'h91C, 32'h0);
    wr(12'h908, 32'hC000_0000);

    // R3: readback follows the selector
    rdExp(12'h904, 32'h4, "R3");
    rdExp(12'h908, 32'hC000_0000, "R3");
    rdExp(12'h918, 32'h032A_0000, "R3");
    wr(12'h900, 32'h0);
    rdExp(12'h904, 32'h0, "R3");
    rdExp(12'h90C, 32'h1000_0000, "R3");
    rdExp(12'h91C, 32'h0000_0080, "R3");
    rdExp(12'h908, 32'h8000_0000, "R3");

    // R5: hits inside, at base, at limit
    req(64'h1_1000_0040); chkRsp(64'h80_0000_0040, 5'd0, 1'b0, 1'b0, "R5");
    req(64'h1_1000_0000); chkRsp(64'h80_0000_0000, 5'd0, 1'b0, 1'b0, "R5");
    req(64'h1_1000_FFFF); chkRsp(64'h80_0000_FFFF, 5'd0, 1'b0, 1'b0, "R5");
    // R7: overlap goes to region 0
    req(64'h1_1000_9000); chkRsp(64'h80_0000_9000, 5'd0, 1'b0, 1'b0, "R7");
    // R5: one past region 0 limit lands in region 1
    req(64'h1_1001_0000); chkRsp(64'h0000_0000_032A_8000, 5'd4, 1'b0, 1'b1, "R5");
    // R9: configuration target fields carried through
    req(64'h1_1001_0FFF); chkRsp(64'h0000_0000_032A_8FFF, 5'd4, 1'b0, 1'b1, "R9");
    nTests++;
    if (rspAddr[31:24] !== 8'd3 || rspAddr[23:19] !== 5'd5 || rspAddr[18:16] !== 3'd2) begin
      nFail++; $display("FAIL R9 bus/dev/func: actual %h expected 03/05/2", rspAddr[31:16]);
    end
    // R8: beyond region 1 and wrong upper word
    req(64'h1_1001_1000); chkRsp(64'h1_1001_1000, 5'd0, 1'b1, 1'b0, "R8");
    req(64'h2_1000_0040); chkRsp(64'h2_1000_0040, 5'd0, 1'b1, 1'b0, "R8");

    // R6: disable region 0
    wr(12'h908, 32'h0);
    req(64'h1_1000_9000); chkRsp(64'h0000_0000_032A_1000, 5'd4, 1'b0, 1'b1, "R6");
    req(64'h1_1000_0040); chkRsp(64'h1_1000_0040, 5'd0, 1'b1, 1'b0, "R6");

    // R4: inbound and out-of-range selections are inert
    wr(12'h900, 32'h8000_0001);
    rdExp(12'h900, 32'h8000_0001, "R4");
    wr(12'h90C, 32'hDEAD_0000);
    rdExp(12'h90C, 32'h0, "R4");
    wr(12'h900, 32'h3);
    wr(12'h914, 32'h0);
    rdExp(12'h914, 32'h0, "R4");
    wr(12'h900, 32'h1);
    rdExp(12'h90C, 32'h1000_8000, "R4");
    rdExp(12'h914, 32'h1001_0FFF, "R4");
    req(64'h1_1001_0000); chkRsp(64'h0000_0000_032A_8000, 5'd4, 1'b0, 1'b1, "R4");

    // R10: write and request on the same edge
    step(1'b1, 12'h914, 32'h1000_FFFF, 1'b1, 64'h1_1001_0000);
    chkRsp(64'h0000_0000_032A_8000, 5'd4, 1'b0, 1'b1, "R10");
    req(64'h1_1001_0000); chkRsp(64'h1_1001_0000, 5'd0, 1'b1, 1'b0, "R10");

    // R9: I/O type carried verbatim
    wr(12'h904, 32'h2);
    req(64'h1_1000_9000); chkRsp(64'h0000_0000_032A_1000, 5'd2, 1'b0, 1'b1, "R9");

    // R11: idle cycle gives no result
    step(1'b0, 12'h000, '0, 1'b0, '0);
    nTests++;
    if (rspValid !== 1'b0) begin
      nFail++; $display("FAIL R11 idle: actual %0b expected 0", rspValid);
    end

    // re-enable region 0 and widen region 1, then random traffic against the model
    wr(12'h914, 32'h1001_FFFF);
    wr(12'h900, 32'h0);
    wr(12'h908, 32'h8000_0000);
    for (int k = 0; k < 400; k++) begin
      logic [63:0] ra;
      ra = ($urandom_range(0, 3) == 0) ? {32'($urandom_range(0, 2)), 32'($urandom)}
                                       : 64'h1_1000_0000 + 64'($urandom_range(0, 32'h2_0000));
      if ($urandom_range(0, 9) == 0)
        step(1'b1, 12'h914, 32'h1000_0000 + 32'($urandom_range(0, 32'hFFFF)),
             $urandom_range(0, 1) == 1, ra);
      else
        step(1'b0, 12'h000, '0, $urandom_range(0, 4) != 0, ra);
    end
    step(1'b0, 12'h000, '0, 1'b0, '0);
    step(1'b0, 12'h000, '0, 1'b0, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule